// File: doc/BRIEF.md
# Fetch-Steal Video and Sync Glue

This block sits between an 8-bit microprocessor bus, an external ROM and RAM, and a plain monochrome video path in a low-cost home computer. It observes one bus cycle per clock (instruction fetch, data read, data write, port input, port output or interrupt acknowledge). From these cycles it steers memory selects, builds the byte returned to the processor, and keeps two sync levels. Vertical sync is raised by a port read at one port number and dropped by a port write at another. Horizontal sync is raised by an interrupt acknowledge and dropped by the next instruction fetch.

Picture data is not produced by a scan counter. When the processor fetches an instruction from the upper half of the address space and the RAM byte there has its marker bit clear, the byte is diverted to the video path with a one-clock strobe. The processor is handed a no-operation code instead, so display memory is "executed" as a run of harmless instructions. The interrupt request is refreshed on every instruction fetch from a chosen bit of the processor's refresh counter, which paces the scan-line interrupts.

Top module: `vfg_top`

## Requirements
- R1: While reset is held and on release, `vsync`, `hsync`, `irq_req` and `vid_strobe` are all 0.
- R2: A valid port-input cycle (kind 3) with low address byte 0xFE sets `vsync` to 1 from the next clock. A valid port-output cycle (kind 4) with low byte 0xFF clears it. Every other port number leaves it unchanged.
- R3: Every valid port-input cycle and every valid interrupt-acknowledge cycle (kind 5) returns 0xFF on `cpu_rdata` in the same cycle.
- R4: A valid interrupt acknowledge sets `hsync` from the next clock. A valid instruction fetch (kind 0) clears it.
- R5: On each valid instruction fetch, `irq_req` becomes 1 from the next clock if bit 6 of `refresh` is 0, and 0 if that bit is 1. Other cycles leave it unchanged.
- R6: A fetch or data read (kind 1) whose address is below 0x2000 asserts `rom_cs` and returns `rom_data`. At or above 0x2000 it asserts `ram_cs` instead.
- R7: A valid write (kind 2) asserts `ram_we` and `ram_cs` at every address, including the ROM range, and passes `cpu_wdata` to `ram_wdata`. Writes and port outputs return 0x00 on `cpu_rdata`.
- R8: A fetch from an address strictly above 0x8000 whose RAM byte has bit 6 clear returns 0x00 to the processor. On the next clock it raises `vid_strobe` for exactly one cycle, with that RAM byte on `vid_byte`.
- R9: Data reads anywhere in RAM, fetches of bytes with bit 6 set, and fetches at 0x8000 or below return the true RAM byte and raise no strobe.
- R10: Cycles with `cyc_valid` low change no sync, interrupt or strobe state, assert no select, and return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A bus cycle is presented this clock |
| cyc_kind | input | 3 | Cycle kind: 0 fetch, 1 read, 2 write, 3 port in, 4 port out, 5 interrupt acknowledge |
| cyc_addr | input | 16 | Bus address |
| cpu_wdata | input | 8 | Processor write data |
| refresh | input | 8 | Processor refresh counter value |
| cpu_rdata | output | 8 | Byte returned to the processor |
| rom_cs | output | 1 | ROM read select |
| rom_data | input | 8 | ROM read data |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| vsync | output | 1 | Vertical sync level |
| hsync | output | 1 | Horizontal sync level |
| irq_req | output | 1 | Interrupt request, active high |
| vid_strobe | output | 1 | One-cycle video byte valid |
| vid_byte | output | 8 | Video byte taken from a diverted fetch |

## Verification
The hardest condition to reach is the steal at the edge of display memory. It needs a fetch, an address just past the region start and a RAM byte with the marker bit clear, and the strict bound at 0x8000 must be told apart from an inclusive one. The bench derives RAM contents arithmetically from the address so both marker values occur across the whole space. It sweeps the address space with fetches and reads in a coprime stride, and it adds fetches exactly at 0x7FFF, 0x8000 and 0x8001, where the RAM byte has the marker bit clear.

// File: rtl/vfg_pkg.sv
package vfg_pkg;
   typedef enum logic [2:0] {
      CK_FETCH  = 3'd0,
      CK_READ   = 3'd1,
      CK_WRITE  = 3'd2,
      CK_IO_IN  = 3'd3,
      CK_IO_OUT = 3'd4,
      CK_INTACK = 3'd5
   } cyc_kind_e;
endpackage

// File: rtl/vfg_decode.sv
module vfg_decode #(
   parameter int ADDR_W        = 16,
   parameter int PORT_W        = 8,
   parameter int ROM_SIZE      = 8192,
   parameter int VID_BASE      = 32768,
   parameter bit VID_INCLUSIVE = 1'b0,
   parameter logic [PORT_W-1:0] VS_ON_PORT  = 8'hFE,
   parameter logic [PORT_W-1:0] VS_OFF_PORT = 8'hFF
) (
   input  logic              valid,
   input  logic [2:0]        kind,
   input  logic [ADDR_W-1:0] addr,
   output logic              is_fetch,
   output logic              is_mrd,
   output logic              is_wr,
   output logic              is_in,
   output logic              is_ack,
   output logic              in_rom,
   output logic              in_vid,
   output logic              vs_on,
   output logic              vs_off
);
   import vfg_pkg::*;

   localparam logic [ADDR_W:0]   ROM_LIM = ROM_SIZE[ADDR_W:0];
   localparam logic [ADDR_W-1:0] VB      = VID_BASE[ADDR_W-1:0];

   cyc_kind_e   k;
   logic        is_out;
   logic        vid_raw;
   logic [PORT_W-1:0] port;

   assign k    = cyc_kind_e'(kind);
   assign port = addr[PORT_W-1:0];

   assign is_fetch = valid && (k == CK_FETCH);
   assign is_mrd   = valid && (k == CK_READ);
   assign is_wr    = valid && (k == CK_WRITE);
   assign is_in    = valid && (k == CK_IO_IN);
   assign is_out   = valid && (k == CK_IO_OUT);
   assign is_ack   = valid && (k == CK_INTACK);

   assign in_rom = ({1'b0, addr} < ROM_LIM);

   generate
      if (VID_INCLUSIVE) begin : g_incl
         assign vid_raw = (addr >= VB);
      end else begin : g_strict
         assign vid_raw = (addr > VB);
      end
   endgenerate

   assign in_vid = vid_raw && !in_rom;
   assign vs_on  = is_in  && (port == VS_ON_PORT);
   assign vs_off = is_out && (port == VS_OFF_PORT);
endmodule

// File: rtl/vfg_sync.sv
module vfg_sync #(
   parameter int REF_W = 8,
   parameter logic [REF_W-1:0] IRQ_MASK = 8'h40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_fetch,
   input  logic             is_ack,
   input  logic             vs_on,
   input  logic             vs_off,
   input  logic [REF_W-1:0] refresh,
   output logic             vsync,
   output logic             hsync,
   output logic             irq_req
);
   logic irq_next;
   assign irq_next = ((refresh & IRQ_MASK) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vsync <= 1'b0;
      end else if (vs_on) begin
         vsync <= 1'b1;
      end else if (vs_off) begin
         vsync <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hsync <= 1'b0;
      end else if (is_ack) begin
         hsync <= 1'b1;
      end else if (is_fetch) begin
         hsync <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_req <= 1'b0;
      end else if (is_fetch) begin
         irq_req <= irq_next;
      end
   end

   // R2
   a_r2_vsync_set: assert property (@(posedge clk) disable iff (!rst_n)
      vs_on |=> vsync);
   a_r2_vsync_clr: assert property (@(posedge clk) disable iff (!rst_n)
      vs_off |=> !vsync);
   // R4
   a_r4_hsync_set: assert property (@(posedge clk) disable iff (!rst_n)
      is_ack |=> hsync);
   a_r4_hsync_clr: assert property (@(posedge clk) disable iff (!rst_n)
      is_fetch |=> !hsync);
   // R5
   a_r5_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
      is_fetch |=> (irq_req == (($past(refresh) & IRQ_MASK) == '0)));
   // R10
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_fetch || is_ack || vs_on || vs_off) |=> $stable({vsync, hsync, irq_req}));
endmodule

// File: rtl/vfg_datamux.sv
module vfg_datamux #(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] STEAL_MASK = 8'h40,
   parameter logic [DATA_W-1:0] NOP_CODE   = 8'h00,
   parameter logic [DATA_W-1:0] FILL_CODE  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_fetch,
   input  logic              is_mrd,
   input  logic              is_wr,
   input  logic              is_in,
   input  logic              is_ack,
   input  logic              in_rom,
   input  logic              in_vid,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [DATA_W-1:0] rom_data,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              rom_cs,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              vid_strobe,
   output logic [DATA_W-1:0] vid_byte
);
   logic any_rd;
   logic steal;

   assign any_rd    = is_fetch || is_mrd;
   assign rom_cs    = any_rd && in_rom;
   assign ram_cs    = (any_rd && !in_rom) || is_wr;
   assign ram_we    = is_wr;
   assign ram_wdata = cpu_wdata;
   assign steal     = is_fetch && in_vid && ((ram_rdata & STEAL_MASK) == '0);

   always_comb begin
      cpu_rdata = '0;
      if (is_in || is_ack) begin
         cpu_rdata = FILL_CODE;
      end else if (any_rd) begin
         if (in_rom) cpu_rdata = rom_data;
         else if (steal) cpu_rdata = NOP_CODE;
         else cpu_rdata = ram_rdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vid_strobe <= 1'b0;
         vid_byte   <= '0;
      end else begin
         vid_strobe <= steal;
         if (steal) vid_byte <= ram_rdata;
      end
   end

   // R3
   a_r3_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (is_in || is_ack) |-> (cpu_rdata == FILL_CODE));
   // R7
   a_r7_write: assert property (@(posedge clk) disable iff (!rst_n)
      is_wr |-> (ram_we && ram_cs && !rom_cs && cpu_rdata == '0));
   // R8
   a_r8_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (is_fetch && in_vid && ((ram_rdata & STEAL_MASK) == '0))
      |=> (vid_strobe && vid_byte == $past(ram_rdata)));
   a_r8_only_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      vid_strobe |-> $past(is_fetch));
   // R9
   a_r9_plain_read: assert property (@(posedge clk) disable iff (!rst_n)
      (is_mrd && !in_rom) |-> (cpu_rdata == ram_rdata));
endmodule

// File: rtl/vfg_top.sv
module vfg_top #(
   parameter int ADDR_W        = 16,
   parameter int DATA_W        = 8,
   parameter int REF_W         = 8,
   parameter int ROM_SIZE      = 8192,
   parameter int VID_BASE      = 32768,
   parameter bit VID_INCLUSIVE = 1'b0,
   parameter logic [REF_W-1:0]  IRQ_MASK   = 8'h40,
   parameter logic [DATA_W-1:0] STEAL_MASK = 8'h40,
   parameter logic [DATA_W-1:0] NOP_CODE   = 8'h00,
   parameter logic [DATA_W-1:0] FILL_CODE  = 8'hFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic [2:0]        cyc_kind,
   input  logic [ADDR_W-1:0] cyc_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [REF_W-1:0]  refresh,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              rom_cs,
   input  logic [DATA_W-1:0] rom_data,
   output logic              ram_cs,
   output logic              ram_we,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              vsync,
   output logic              hsync,
   output logic              irq_req,
   output logic              vid_strobe,
   output logic [DATA_W-1:0] vid_byte
);
   localparam int PORT_W = 8;

   generate
      if (ADDR_W < PORT_W || ADDR_W > 24) begin : g_bad_addr
         $error("vfg_top: ADDR_W out of range");
      end
      if (ROM_SIZE < 1 || ROM_SIZE > VID_BASE) begin : g_bad_rom
         $error("vfg_top: ROM_SIZE must lie in 1..VID_BASE");
      end
      if (VID_BASE >= (1 << ADDR_W)) begin : g_bad_base
         $error("vfg_top: VID_BASE outside address space");
      end
      if (IRQ_MASK == '0 || STEAL_MASK == '0) begin : g_bad_mask
         $error("vfg_top: masks must select at least one bit");
      end
   endgenerate

   logic is_fetch, is_mrd, is_wr, is_in, is_ack;
   logic in_rom, in_vid, vs_on, vs_off;

   vfg_decode #(
      .ADDR_W(ADDR_W), .PORT_W(PORT_W), .ROM_SIZE(ROM_SIZE),
      .VID_BASE(VID_BASE), .VID_INCLUSIVE(VID_INCLUSIVE),
      .VS_ON_PORT(8'hFE), .VS_OFF_PORT(8'hFF)
   ) u_decode (
      .valid(cyc_valid), .kind(cyc_kind), .addr(cyc_addr),
      .is_fetch(is_fetch), .is_mrd(is_mrd), .is_wr(is_wr),
      .is_in(is_in), .is_ack(is_ack), .in_rom(in_rom),
      .in_vid(in_vid), .vs_on(vs_on), .vs_off(vs_off)
   );

   vfg_sync #(.REF_W(REF_W), .IRQ_MASK(IRQ_MASK)) u_sync (
      .clk(clk), .rst_n(rst_n), .is_fetch(is_fetch), .is_ack(is_ack),
      .vs_on(vs_on), .vs_off(vs_off), .refresh(refresh),
      .vsync(vsync), .hsync(hsync), .irq_req(irq_req)
   );

   vfg_datamux #(
      .DATA_W(DATA_W), .STEAL_MASK(STEAL_MASK),
      .NOP_CODE(NOP_CODE), .FILL_CODE(FILL_CODE)
   ) u_datamux (
      .clk(clk), .rst_n(rst_n), .is_fetch(is_fetch), .is_mrd(is_mrd),
      .is_wr(is_wr), .is_in(is_in), .is_ack(is_ack), .in_rom(in_rom),
      .in_vid(in_vid), .cpu_wdata(cpu_wdata), .rom_data(rom_data),
      .ram_rdata(ram_rdata), .cpu_rdata(cpu_rdata), .rom_cs(rom_cs),
      .ram_cs(ram_cs), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .vid_strobe(vid_strobe), .vid_byte(vid_byte)
   );

   // R1
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!vsync && !hsync && !irq_req && !vid_strobe));
   // R10
   a_r10_idle_sel: assert property (@(posedge clk) disable iff (!rst_n)
      !cyc_valid |-> (!rom_cs && !ram_cs && !ram_we && cpu_rdata == '0));
endmodule

// File: tb/tb_vfg_top.sv
`timescale 1ns/1ps
module tb_vfg_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_valid = 1'b0;
   logic [2:0]  cyc_kind = 3'd0;
   logic [15:0] cyc_addr = 16'h0;
   logic [7:0]  cpu_wdata = 8'h0;
   logic [7:0]  refresh = 8'h0;
   logic [7:0]  cpu_rdata, rom_data, ram_wdata, ram_rdata, vid_byte;
   logic        rom_cs, ram_cs, ram_we, vsync, hsync, irq_req, vid_strobe;

   int n_chk = 0;
   int n_fail = 0;
   logic ev = 0, eh = 0, ei = 0, es = 0;
   logic [7:0] eb = 8'h00;

   always #5 clk = ~clk;

   function automatic logic [7:0] rom_fn(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'hA5;
   endfunction
   function automatic logic [7:0] ram_fn(input logic [15:0] a);
      return a[7:0] + a[15:8] + 8'h11;
   endfunction

   assign rom_data  = rom_fn(cyc_addr);
   assign ram_rdata = ram_fn(cyc_addr);

   vfg_top dut (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_kind(cyc_kind),
      .cyc_addr(cyc_addr), .cpu_wdata(cpu_wdata), .refresh(refresh),
      .cpu_rdata(cpu_rdata), .rom_cs(rom_cs), .rom_data(rom_data),
      .ram_cs(ram_cs), .ram_we(ram_we), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .vsync(vsync), .hsync(hsync), .irq_req(irq_req),
      .vid_strobe(vid_strobe), .vid_byte(vid_byte)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Drives one cycle starting at a falling edge, returns at the next falling edge.
   task automatic bus(input logic v, input logic [2:0] k, input logic [15:0] a,
                      input logic [7:0] wd, input logic [7:0] rf);
      logic [7:0] xr;
      logic steal, rd, rom;
      cyc_valid = v; cyc_kind = k; cyc_addr = a; cpu_wdata = wd; refresh = rf;
      #1;
      rd    = v && (k == 3'd0 || k == 3'd1);
      rom   = (a < 16'h2000);
      steal = v && k == 3'd0 && a > 16'h8000 && !ram_fn(a)[6];
      if (!v) xr = 8'h00;
      else if (k == 3'd3 || k == 3'd5) xr = 8'hFF;
      else if (rd) xr = rom ? rom_fn(a) : (steal ? 8'h00 : ram_fn(a));
      else xr = 8'h00;
      chk(cpu_rdata == xr, "R3/R6/R8/R9/R10 rdata", {8'h0, cpu_rdata}, {8'h0, xr});
      chk(rom_cs == (rd && rom), "R6 rom_cs", {15'h0, rom_cs}, {15'h0, rd && rom});
      chk(ram_cs == ((rd && !rom) || (v && k == 3'd2)), "R6/R7 ram_cs",
          {15'h0, ram_cs}, {15'h0, (rd && !rom) || (v && k == 3'd2)});
      chk(ram_we == (v && k == 3'd2), "R7 ram_we", {15'h0, ram_we}, {15'h0, v && k == 3'd2});
      if (v && k == 3'd2)
         chk(ram_wdata == wd, "R7 ram_wdata", {8'h0, ram_wdata}, {8'h0, wd});
      if (v) begin
         if (k == 3'd3 && a[7:0] == 8'hFE) ev = 1'b1;
         if (k == 3'd4 && a[7:0] == 8'hFF) ev = 1'b0;
         if (k == 3'd5) eh = 1'b1;
         if (k == 3'd0) begin eh = 1'b0; ei = !rf[6]; end
      end
      es = steal;
      if (steal) eb = ram_fn(a);
      @(posedge clk);
      @(negedge clk);
      chk(vsync == ev, "R2 vsync", {15'h0, vsync}, {15'h0, ev});
      chk(hsync == eh, "R4 hsync", {15'h0, hsync}, {15'h0, eh});
      chk(irq_req == ei, "R5 irq_req", {15'h0, irq_req}, {15'h0, ei});
      chk(vid_strobe == es, "R8 vid_strobe", {15'h0, vid_strobe}, {15'h0, es});
      chk(vid_byte == eb, "R8 vid_byte", {8'h0, vid_byte}, {8'h0, eb});
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: quiet outputs in reset and right after release
      chk(!vsync && !hsync && !irq_req && !vid_strobe, "R1 reset state",
          {12'h0, vsync, hsync, irq_req, vid_strobe}, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!vsync && !hsync && !irq_req && !vid_strobe, "R1 after release",
          {12'h0, vsync, hsync, irq_req, vid_strobe}, 16'h0);

      // R2/R3: all port numbers, input then output
      for (int p = 0; p < 256; p++) begin
         bus(1'b1, 3'd3, {8'h3C, p[7:0]}, 8'h00, 8'h00);
         bus(1'b1, 3'd4, {8'h12, p[7:0]}, 8'h00, 8'h00);
      end
      bus(1'b1, 3'd3, 16'h00FE, 8'h00, 8'h00);
      chk(vsync == 1'b1, "R2 vsync high for idle test", {15'h0, vsync}, 16'h1);

      // R10: idle cycles with trigger-like inputs change nothing
      bus(1'b0, 3'd4, 16'h00FF, 8'h00, 8'h00);
      bus(1'b0, 3'd5, 16'h0000, 8'h00, 8'h00);
      bus(1'b0, 3'd0, 16'h9001, 8'h00, 8'h40);
      bus(1'b0, 3'd2, 16'h4000, 8'h33, 8'h00);

      // R4/R5: every refresh value, alternating acknowledge and fetch
      for (int r = 0; r < 256; r++) begin
         bus(1'b1, 3'd5, 16'h0038, 8'h00, 8'h00);
         bus(1'b1, 3'd1, 16'h0100, 8'h00, 8'h00);
         bus(1'b1, 3'd0, 16'h0200, 8'h00, r[7:0]);
      end

      // R6-R9: address sweep with fetch, read, write
      for (int a = 0; a < 65536; a += 97) begin
         bus(1'b1, 3'd0, a[15:0], 8'h00, a[7:0]);
         bus(1'b1, 3'd1, a[15:0], 8'h00, 8'h00);
         bus(1'b1, 3'd2, a[15:0], a[15:8] ^ 8'h5C, 8'h00);
      end

      // R6/R8/R9 boundaries; 0x8000 and 0x8001 hold bytes with bit 6 clear
      bus(1'b1, 3'd0, 16'h1FFF, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'h2000, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'h7FFF, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'h8000, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'h8001, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'h8001, 8'h00, 8'h00);
      bus(1'b1, 3'd1, 16'h8001, 8'h00, 8'h00);
      bus(1'b1, 3'd0, 16'hFFFF, 8'h00, 8'h00);
      bus(1'b1, 3'd2, 16'h0000, 8'hA7, 8'h00);
      bus(1'b1, 3'd0, 16'h802F, 8'h00, 8'h00);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule